// File: doc/BRIEF.md
# Two-Level Gated Configuration Register Bank

This block is a bank of eight 32-bit configuration registers behind an APB slave port. Register storage is arranged so that clock enables can be derived at two levels. The first level opens only while a write access phase is in progress on the bus. The second level opens only for the register group that the address selects.

The registers are split by how often the host writes them. Group 0 holds set-once configuration words. Group 1 holds words the host rewrites often. Within a group, all four registers share one load enable. Registers that are not addressed reload their own value, so the group needs no per-register enable.

The first word of group 1 is a control register. Its low byte is a packet-length field, which is often rewritten with an unchanged value. That byte therefore has its own load enable, raised only when the incoming byte differs from the stored byte. A one-cycle status pulse reports each real change of the length field. All register contents are presented on a flat output bus for use by the surrounding logic.

Top module: `cfg_reg_bank`

## Requirements
- R1: While `presetn` is low, every register is zero and `len_update_o` is low. After release, `prdata` reads zero whenever `psel` is low.
- R2: A register loads `pwdata` only at a rising `pclk` edge where `psel`, `penable` and `pwrite` are all high. The new value appears on `cfg_regs_o` after that edge. A setup phase (`penable` low), a read, or `penable` without `psel` changes nothing.
- R3: Address bits 7:5 must be zero for an access to map. Bit 4 selects the group and bits 3:2 select the word in the group. Group 0 is offsets 0x00, 0x04, 0x08 and 0x0C; group 1 is offsets 0x10 to 0x1C. A write changes only the addressed register; every register of the other group and the other words of its own group stay unchanged.
- R4: The control register is at offset 0x10. Its bits 31:8 take the written data on every write to that offset.
- R5: Bits 7:0 of the control register form the packet-length field. After a write to 0x10, the field equals the written byte. The field's load enable fires only when the written byte differs from the stored byte.
- R6: `len_update_o` is high for exactly the one cycle after a write to 0x10 whose bits 7:0 differ from the stored length. It is low after any other write, including a same-length write to 0x10 and writes to other offsets.
- R7: During a read (`psel` high, `pwrite` low), `prdata` combinationally returns the addressed register; address bits 1:0 are ignored. Reads of unmapped offsets (0x20 and above) return zero. Writes to unmapped offsets change no register.
- R8: `pready` is always high, so every access completes in its first access-phase cycle.
- R9: `cfg_regs_o[32*k +: 32]` holds the register at offset 4*k, for k from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | High for write, low for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| pready | output | 1 | Transfer-complete, constant high |
| cfg_regs_o | output | 256 | All eight registers, word k at bits 32*k+31:32*k |
| len_update_o | output | 1 | One-cycle pulse after a real packet-length change |

## Verification
A write is committed at the rising edge that ends its access phase. Both the register bus and the length pulse are registered at that same edge. The bench therefore samples them at the following falling edge, and checks the pulse again one cycle later to confirm that it has cleared. Read data is combinational, so the bench checks it one nanosecond after the access phase is driven, before the next edge. Inputs that must be ignored are held for several cycles before the whole register bus is compared with the model.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned ADDR_W       = 8;
    localparam int unsigned GRP_N        = 2;
    localparam int unsigned REGS_PER_GRP = 4;
    localparam int unsigned LEN_W        = 8;
    localparam int unsigned CTRL_GRP     = 1;
    localparam int unsigned CTRL_IDX     = 0;
    localparam int unsigned BYTE_LSB     = 2;
    localparam int unsigned IDX_W        = $clog2(REGS_PER_GRP);
    localparam int unsigned GRP_W        = $clog2(GRP_N);
    localparam int unsigned GRP_LSB      = BYTE_LSB + IDX_W;
    localparam int unsigned MAP_MSB      = GRP_LSB + GRP_W;
    localparam int unsigned REG_TOTAL    = GRP_N * REGS_PER_GRP;
    localparam int unsigned GRP_BITS     = REGS_PER_GRP * DATA_W;

    typedef struct packed {
        logic             bank_wr_en;
        logic             rd_sel;
        logic             mapped;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] idx;
        logic [GRP_N-1:0] grp_en;
    } dec_t;
endpackage

// File: rtl/cfg_bank_decode.sv
module cfg_bank_decode
    import cfg_bank_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec_o
);
    logic [GRP_N-1:0] grp_hit;
    logic             unused_lsb;

    assign unused_lsb = ^paddr[BYTE_LSB-1:0];

    for (genvar g = 0; g < GRP_N; g++) begin : g_hit
        assign grp_hit[g] = (paddr[GRP_LSB +: GRP_W] == GRP_W'(g));
    end

    always_comb begin
        dec_o            = '0;
        // first level: a write access phase on this slave
        dec_o.bank_wr_en = psel & penable & pwrite;
        dec_o.rd_sel     = psel & ~pwrite;
        dec_o.mapped     = (paddr[ADDR_W-1:MAP_MSB] == '0);
        dec_o.grp        = paddr[GRP_LSB +: GRP_W];
        dec_o.idx        = paddr[BYTE_LSB +: IDX_W];
        // second level: only the addressed group
        dec_o.grp_en     = grp_hit & {GRP_N{dec_o.bank_wr_en & dec_o.mapped}};
    end
endmodule

// File: rtl/cfg_len_guard.sv
module cfg_len_guard #(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               wr_sel,
    input  logic [FIELD_W-1:0] stored_i,
    input  logic [FIELD_W-1:0] new_i,
    output logic               load_o
);
    logic [FIELD_W-1:0] diff;

    assign diff   = stored_i ^ new_i;
    assign load_o = wr_sel & (|diff);
endmodule

// File: rtl/cfg_reg_group.sv
module cfg_reg_group
    import cfg_bank_pkg::*;
#(
    parameter int unsigned NREG    = REGS_PER_GRP,
    parameter bit          HAS_LEN = 1'b0,
    parameter int unsigned LEN_IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   grp_en_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [NREG*DATA_W-1:0] regs_o,
    output logic                   len_pulse_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        len_pulse;
    } grp_st_t;

    grp_st_t st_d;
    grp_st_t st_q;
    logic    len_load;

    if (HAS_LEN) begin : g_len
        cfg_len_guard #(.FIELD_W(LEN_W)) u_guard (
            .wr_sel   (grp_en_i && (idx_i == IDX_W'(LEN_IDX))),
            .stored_i (st_q.regs[LEN_IDX][LEN_W-1:0]),
            .new_i    (wdata_i[LEN_W-1:0]),
            .load_o   (len_load)
        );
    end else begin : g_nolen
        assign len_load = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (idx_i == IDX_W'(i)) begin
                st_d.regs[i] = wdata_i;
            end
        end
        st_d.len_pulse = len_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q.len_pulse <= st_d.len_pulse;
            // one shared enable for every word of the group
            if (grp_en_i) begin
                for (int i = 0; i < NREG; i++) begin
                    if (HAS_LEN && (i == int'(LEN_IDX))) begin
                        st_q.regs[i][DATA_W-1:LEN_W] <= st_d.regs[i][DATA_W-1:LEN_W];
                    end else begin
                        st_q.regs[i] <= st_d.regs[i];
                    end
                end
            end
            // change-detect enable for the length byte only
            if (len_load) begin
                st_q.regs[LEN_IDX][LEN_W-1:0] <= st_d.regs[LEN_IDX][LEN_W-1:0];
            end
        end
    end

    assign regs_o      = st_q.regs;
    assign len_pulse_o = st_q.len_pulse;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_bank_pkg::*;
(
    input  logic                        pclk,
    input  logic                        presetn,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [DATA_W-1:0]           pwdata,
    output logic [DATA_W-1:0]           prdata,
    output logic                        pready,
    output logic [REG_TOTAL*DATA_W-1:0] cfg_regs_o,
    output logic                        len_update_o
);
    dec_t                                dec;
    logic [GRP_N-1:0]                    grp_pulse;
    logic [REG_TOTAL-1:0][DATA_W-1:0]    rd_words;

    cfg_bank_decode u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .dec_o   (dec)
    );

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        cfg_reg_group #(
            .NREG    (REGS_PER_GRP),
            .HAS_LEN (bit'(g == CTRL_GRP)),
            .LEN_IDX (CTRL_IDX)
        ) u_grp (
            .clk         (pclk),
            .rst_n       (presetn),
            .grp_en_i    (dec.grp_en[g]),
            .idx_i       (dec.idx),
            .wdata_i     (pwdata),
            .regs_o      (cfg_regs_o[g*GRP_BITS +: GRP_BITS]),
            .len_pulse_o (grp_pulse[g])
        );
    end

    assign rd_words     = cfg_regs_o;
    assign len_update_o = |grp_pulse;
    assign pready       = 1'b1;

    always_comb begin
        prdata = '0;
        if (dec.rd_sel && dec.mapped) begin
            prdata = rd_words[{dec.grp, dec.idx}];
        end
    end
endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk
    import cfg_bank_pkg::*;
(
    input logic                        pclk,
    input logic                        presetn,
    input logic                        psel,
    input logic                        penable,
    input logic                        pwrite,
    input logic [ADDR_W-1:0]           paddr,
    input logic [DATA_W-1:0]           pwdata,
    input logic [DATA_W-1:0]           prdata,
    input logic [REG_TOTAL*DATA_W-1:0] cfg_regs_o,
    input logic                        len_update_o
);
    logic              wr_acc;
    logic              ctrl_wr;
    logic              unmapped;
    logic              len_diff;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_acc    = psel && penable && pwrite;
    assign unmapped  = (paddr[ADDR_W-1:MAP_MSB] != '0);
    assign ctrl_wr   = wr_acc && !unmapped && (paddr[GRP_LSB +: GRP_W] == GRP_W'(CTRL_GRP))
                       && (paddr[BYTE_LSB +: IDX_W] == IDX_W'(CTRL_IDX));
    assign ctrl_word = cfg_regs_o[(CTRL_GRP*REGS_PER_GRP + CTRL_IDX)*DATA_W +: DATA_W];
    assign len_diff  = (pwdata[LEN_W-1:0] != ctrl_word[LEN_W-1:0]);

    p_hold_idle_r2: assert property (@(posedge pclk) disable iff (!presetn)
        !wr_acc |=> $stable(cfg_regs_o));

    p_grp1_iso_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_acc && !unmapped && paddr[GRP_LSB +: GRP_W] == '0) |=> $stable(cfg_regs_o[GRP_BITS +: GRP_BITS]));

    p_grp0_iso_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_acc && !unmapped && paddr[GRP_LSB +: GRP_W] != '0) |=> $stable(cfg_regs_o[0 +: GRP_BITS]));

    p_upper_load_r4: assert property (@(posedge pclk) disable iff (!presetn)
        ctrl_wr |=> (ctrl_word[DATA_W-1:LEN_W] == $past(pwdata[DATA_W-1:LEN_W])));

    p_len_value_r5: assert property (@(posedge pclk) disable iff (!presetn)
        ctrl_wr |=> (ctrl_word[LEN_W-1:0] == $past(pwdata[LEN_W-1:0])));

    p_len_pulse_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (ctrl_wr && len_diff) |=> len_update_o);

    p_len_quiet_r6: assert property (@(posedge pclk) disable iff (!presetn)
        !(ctrl_wr && len_diff) |=> !len_update_o);

    p_unmapped_rd_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && unmapped) |-> (prdata == '0));

    p_unmapped_wr_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_acc && unmapped) |=> $stable(cfg_regs_o));
endmodule

bind cfg_reg_bank cfg_reg_bank_chk u_chk (
    .pclk         (pclk),
    .presetn      (presetn),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .prdata       (prdata),
    .cfg_regs_o   (cfg_regs_o),
    .len_update_o (len_update_o)
);

// File: tb/cfg_reg_bank_tb.sv
`timescale 1ns/1ps
module cfg_reg_bank_tb;
    logic         clk = 1'b0;
    logic         presetn;
    logic         psel, penable, pwrite;
    logic [7:0]   paddr;
    logic [31:0]  pwdata;
    logic [31:0]  prdata;
    logic         pready;
    logic [255:0] cfg_regs_o;
    logic         len_update_o;

    int           total = 0;
    int           bad   = 0;
    bit           done  = 1'b0;
    logic [31:0]  exp_regs [8];

    always #4 clk = ~clk;

    cfg_reg_bank u_dut (
        .pclk         (clk),
        .presetn      (presetn),
        .psel         (psel),
        .penable      (penable),
        .pwrite       (pwrite),
        .paddr        (paddr),
        .pwdata       (pwdata),
        .prdata       (prdata),
        .pready       (pready),
        .cfg_regs_o   (cfg_regs_o),
        .len_update_o (len_update_o)
    );

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        for (int k = 0; k < 8; k++) begin
            chk32($sformatf("%s R9 word%0d", tag, k), cfg_regs_o[k*32 +: 32], exp_regs[k]);
        end
    endtask

    task automatic apb_wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = addr; pwdata = data;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        if (addr < 8'h20) exp_regs[addr[4:2]] = data;
    endtask

    task automatic apb_rd(input logic [7:0] addr, output logic [31:0] data, output logic rdy);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = addr;
        @(negedge clk);
        penable = 1'b1;
        #1;
        data = prdata;
        rdy  = pready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        chk_regs("R1 reset");
        chk32("R1 len_update_o at reset", {31'd0, len_update_o}, 32'd0);
        chk32("R1 prdata idle", prdata, 32'd0);
    endtask

    task automatic t_group0();
        apb_wr(8'h00, 32'h1111_0001);
        apb_wr(8'h04, 32'h2222_0002);
        apb_wr(8'h08, 32'h3333_0003);
        apb_wr(8'h0C, 32'h4444_0004);
        chk_regs("R2 R3 group0 writes");
        chk32("R6 no pulse for group0", {31'd0, len_update_o}, 32'd0);
    endtask

    task automatic t_group1();
        apb_wr(8'h14, 32'hA5A5_0014);
        chk_regs("R3 single group1 word");
        apb_wr(8'h18, 32'h5A5A_0018);
        apb_wr(8'h1C, 32'hDEAD_BEEF);
        chk_regs("R3 group1 writes");
    endtask

    task automatic t_ctrl();
        apb_wr(8'h10, 32'hAABB_CC12);
        chk32("R6 pulse on new length", {31'd0, len_update_o}, 32'd1);
        chk32("R4 R5 ctrl after first write", cfg_regs_o[4*32 +: 32], 32'hAABB_CC12);
        @(negedge clk);
        chk32("R6 pulse lasts one cycle", {31'd0, len_update_o}, 32'd0);
        apb_wr(8'h10, 32'h5566_7712);
        chk32("R6 no pulse on same length", {31'd0, len_update_o}, 32'd0);
        chk32("R4 upper bits on same-length write", cfg_regs_o[4*32 +: 32], 32'h5566_7712);
        apb_wr(8'h10, 32'h5566_77FF);
        chk32("R6 pulse on changed length", {31'd0, len_update_o}, 32'd1);
        chk32("R5 new length stored", cfg_regs_o[4*32 +: 32], 32'h5566_77FF);
        apb_wr(8'h14, 32'h0000_0033);
        chk32("R6 no pulse for other group1 word", {31'd0, len_update_o}, 32'd0);
        chk_regs("R3 after ctrl sequence");
    endtask

    task automatic t_no_access();
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h04; pwdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        psel = 1'b0; penable = 1'b1; paddr = 8'h10;
        repeat (3) @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 8'h18;
        repeat (2) @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);
        chk_regs("R2 no write without access phase");
        chk32("R6 no pulse without access", {31'd0, len_update_o}, 32'd0);
    endtask

    task automatic t_reads();
        logic [31:0] d;
        logic        r;
        for (int k = 0; k < 8; k++) begin
            apb_rd(8'(k*4 + (k % 4)), d, r);
            chk32($sformatf("R7 read word%0d", k), d, exp_regs[k]);
            chk32($sformatf("R8 pready word%0d", k), {31'd0, r}, 32'd1);
        end
        apb_rd(8'h20, d, r);
        chk32("R7 unmapped read 0x20", d, 32'd0);
        apb_rd(8'hFC, d, r);
        chk32("R7 unmapped read 0xFC", d, 32'd0);
        chk32("R8 pready unmapped", {31'd0, r}, 32'd1);
        apb_wr(8'h24, 32'h9999_9999);
        apb_wr(8'hF0, 32'h7777_7777);
        chk_regs("R7 unmapped writes ignored");
        chk32("R1 prdata with psel low", prdata, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) exp_regs[k] = 32'd0;
        presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = 8'h00; pwdata = 32'd0;
        repeat (3) @(negedge clk);
        t_reset();
        presetn = 1'b1;
        @(negedge clk);
        t_group0();
        t_group1();
        t_ctrl();
        t_no_access();
        t_reads();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule